// File: doc/BRIEF.md
# 40-bit Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a 16-bit DSP-style core. It holds two 40-bit accumulators. Each clock it can take one operation: a 16x16 multiply of two register operands, either unsigned by unsigned or signed (first operand) by unsigned (second operand). The product is added into the chosen accumulator. Sums wrap at 40 bits and never saturate.

A fractional-mode bit doubles the product before it is added. The core supplies this bit as bit 7 of its control word, and the bit is taken in the same cycle as the operation. A preset port writes a full 40-bit value into either accumulator, and both accumulators are always visible on the read port. Instruction decode, the register file, saturation and rounding belong to the surrounding core.

Top module: `mac40_unit`

## Requirements
- R1: With `op_sel` = 0 (unsigned mode), both operands are zero-extended and multiplied at full 32-bit precision. Example: accumulator 0x7F_FFFF_FFFF, operands 0x8001 and 0xFFFF, fractional mode off, gives 0x80_8000_7FFE.
- R2: With `op_sel` = 1 (signed-by-unsigned mode), `op_a` is a two's-complement 16-bit value and `op_b` is unsigned, and the product is sign-extended to 40 bits. From an accumulator of 0x7F_FFFF_FFFF with `op_b` = 0xFFFF, `op_a` = 0x7FFF gives 0x80_7FFE_8000 and `op_a` = 0x8001 gives 0x7F_8001_7FFE.
- R3: The new accumulator value is (old value + product) modulo 2^40, and any carry out of bit 39 is dropped.
- R4: When bit 7 of `ctl_word` is 1, the product is shifted left by one before it is added. The other bits of `ctl_word` have no effect. Examples in fractional mode: unsigned 0x8001 x 0xFFFF onto 0x7F_FFFF_FFFF gives 0x81_0000_FFFD; signed-by-unsigned gives 0x80_FFFD_0001 for `op_a` = 0x7FFF and 0x7F_0002_FFFD for `op_a` = 0x8001.
- R5: The fractional bit is sampled in the cycle of the valid strobe, so each operation uses its own mode, even when operations are back to back.
- R6: `op_acc` selects the target accumulator (0 or 1). The accumulator that is not selected keeps its value.
- R7: The result appears on `acc_q` on the clock edge that accepts the strobe. One operation per cycle is accepted, so back-to-back operations on the same accumulator all add up.
- R8: When `preset_en` is 1, `preset_val` is written into accumulator `preset_idx` at the next edge. On that accumulator, the preset wins over an accumulate in the same cycle. An accumulate aimed at the other accumulator in that cycle still takes effect.
- R9: A synchronous active-high `rst` clears both accumulators to zero. Reset wins over a preset and over an accumulate.
- R10: When neither `op_valid` nor `preset_en` is 1, both accumulators hold their value, whatever the operand and control inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 1 | 0 = unsigned x unsigned, 1 = signed x unsigned |
| op_acc | input | 1 | Target accumulator index |
| op_a | input | 16 | First operand (signed in mode 1) |
| op_b | input | 16 | Second operand (always unsigned) |
| ctl_word | input | 16 | Control word; bit 7 enables fractional mode |
| preset_en | input | 1 | Preset strobe |
| preset_idx | input | 1 | Accumulator to preset |
| preset_val | input | 40 | Preset value |
| acc_q | output | 2x40 | Both accumulators, index 0 in the low word |

## Verification
Some properties are checked by the assertions on every cycle:
- the multiplier's zero-extended width in unsigned mode;
- the sign of negative signed-by-unsigned products;
- the even product in fractional mode;
- the accumulate step as a 40-bit sum;
- preset loading, idle hold and reset clearing.

Other behaviour only the bench scenarios can show:
- the exact product values for the given operand pairs;
- wrap-around past 2^40;
- per-operation sampling of the fractional bit across back-to-back issues;
- which operation wins when a preset and an accumulate meet on the same accumulator or on different ones.

// File: rtl/mac40_pkg.sv
package mac40_pkg;

  typedef enum logic {
    MUL_UU = 1'b0,
    MUL_SU = 1'b1
  } mul_mode_e;

endpackage

// File: rtl/mac40_mult.sv
module mac40_mult #(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input  logic                  mode_su,
  input  logic                  frac,
  input  logic [OPW-1:0]        a,
  input  logic [OPW-1:0]        b,
  output logic [ACCW-1:0]       prod_ext
);

  localparam int PW  = 2 * OPW + 2;
  localparam int EXT = ACCW - PW;

  // Full-precision product. Operand a is optionally signed, b is always
  // unsigned. Result is sign-extended to the accumulator width and doubled in
  // fractional mode.
  function automatic logic [ACCW-1:0] form_product(
    input logic [OPW-1:0] fa,
    input logic [OPW-1:0] fb,
    input logic           a_signed,
    input logic           dbl
  );
    logic signed [OPW:0]    ax;
    logic signed [OPW:0]    bx;
    logic signed [PW-1:0]   p;
    logic        [ACCW-1:0] w;
    ax = {a_signed & fa[OPW-1], fa};
    bx = {1'b0, fb};
    p  = PW'(ax) * PW'(bx);
    w  = {{EXT{p[PW-1]}}, p};
    if (dbl) w = {w[ACCW-2:0], 1'b0};
    return w;
  endfunction

  always_comb prod_ext = form_product(a, b, mode_su, frac);

endmodule

// File: rtl/mac40_route.sv
module mac40_route #(
  parameter int NACC = 2,
  parameter int IDXW = (NACC > 1) ? $clog2(NACC) : 1
) (
  input  logic            op_valid,
  input  logic [IDXW-1:0] op_acc,
  input  logic            preset_en,
  input  logic [IDXW-1:0] preset_idx,
  output logic [NACC-1:0] upd_pre,
  output logic [NACC-1:0] upd_acc
);

  for (genvar i = 0; i < NACC; i++) begin : g_sel
    always_comb begin
      upd_pre[i] = preset_en && (preset_idx == IDXW'(i));
      upd_acc[i] = op_valid && (op_acc == IDXW'(i)) && !upd_pre[i];
    end
  end

endmodule

// File: rtl/mac40_acc_bank.sv
module mac40_acc_bank #(
  parameter int NACC = 2,
  parameter int ACCW = 40
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NACC-1:0]           upd_pre,
  input  logic [NACC-1:0]           upd_acc,
  input  logic [ACCW-1:0]           prod_ext,
  input  logic [ACCW-1:0]           preset_val,
  output logic [NACC-1:0][ACCW-1:0] acc_q
);

  // Modulo-2^ACCW addition; the carry out of the top bit is discarded.
  function automatic logic [ACCW-1:0] add_wrap(
    input logic [ACCW-1:0] x,
    input logic [ACCW-1:0] y
  );
    logic [ACCW:0] s;
    s = {1'b0, x} + {1'b0, y};
    return s[ACCW-1:0];
  endfunction

  for (genvar i = 0; i < NACC; i++) begin : g_acc
    logic [ACCW-1:0] sum_nxt;
    always_comb sum_nxt = add_wrap(acc_q[i], prod_ext);

    always_ff @(posedge clk) begin
      if (rst)             acc_q[i] <= '0;
      else if (upd_pre[i]) acc_q[i] <= preset_val;
      else if (upd_acc[i]) acc_q[i] <= sum_nxt;
    end
  end

endmodule

// File: rtl/mac40_unit.sv
module mac40_unit #(
  parameter int OPW      = 16,
  parameter int ACCW     = 40,
  parameter int NACC     = 2,
  parameter int CTLW     = 16,
  parameter int FRAC_BIT = 7,
  parameter int IDXW     = (NACC > 1) ? $clog2(NACC) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      op_valid,
  input  logic                      op_sel,
  input  logic [IDXW-1:0]           op_acc,
  input  logic [OPW-1:0]            op_a,
  input  logic [OPW-1:0]            op_b,
  input  logic [CTLW-1:0]           ctl_word,
  input  logic                      preset_en,
  input  logic [IDXW-1:0]           preset_idx,
  input  logic [ACCW-1:0]           preset_val,
  output logic [NACC-1:0][ACCW-1:0] acc_q
);

  import mac40_pkg::*;

  mul_mode_e       mode;
  logic            frac_now;
  logic [ACCW-1:0] prod_ext;
  logic [NACC-1:0] upd_pre;
  logic [NACC-1:0] upd_acc;

  always_comb begin
    mode     = mul_mode_e'(op_sel);
    frac_now = ctl_word[FRAC_BIT];
  end

  mac40_mult #(.OPW(OPW), .ACCW(ACCW)) u_mult (
    .mode_su  (mode == MUL_SU),
    .frac     (frac_now),
    .a        (op_a),
    .b        (op_b),
    .prod_ext (prod_ext)
  );

  mac40_route #(.NACC(NACC), .IDXW(IDXW)) u_route (
    .op_valid   (op_valid),
    .op_acc     (op_acc),
    .preset_en  (preset_en),
    .preset_idx (preset_idx),
    .upd_pre    (upd_pre),
    .upd_acc    (upd_acc)
  );

  mac40_acc_bank #(.NACC(NACC), .ACCW(ACCW)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .upd_pre    (upd_pre),
    .upd_acc    (upd_acc),
    .prod_ext   (prod_ext),
    .preset_val (preset_val),
    .acc_q      (acc_q)
  );

endmodule

// File: rtl/mac40_unit_chk.sv
module mac40_unit_chk #(
  parameter int OPW  = 16,
  parameter int ACCW = 40,
  parameter int NACC = 2,
  parameter int IDXW = 1
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      op_valid,
  input logic                      op_sel,
  input logic [IDXW-1:0]           op_acc,
  input logic [OPW-1:0]            op_a,
  input logic [OPW-1:0]            op_b,
  input logic                      frac_now,
  input logic                      preset_en,
  input logic [IDXW-1:0]           preset_idx,
  input logic [ACCW-1:0]           preset_val,
  input logic [ACCW-1:0]           prod_ext,
  input logic [NACC-1:0][ACCW-1:0] acc_q
);

  // R9: reset clears every accumulator
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (acc_q == '0));

  // R1: unsigned product in normal mode fits in 2*OPW bits
  p_uu_width_r1: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_sel && !frac_now) |-> (prod_ext[ACCW-1:2*OPW] == '0));

  // R2: negative signed operand times nonzero unsigned gives a negative product
  p_su_sign_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel && op_a[OPW-1] && (op_b != '0)) |-> prod_ext[ACCW-1]);

  // R4: fractional mode always yields an even product
  p_frac_even_r4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && frac_now) |-> !prod_ext[0]);

  // R3 / R7: accepted accumulate lands one edge later as a wrapped sum
  p_accum_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !(preset_en && (preset_idx == op_acc)))
    |=> (acc_q[$past(op_acc)] == ACCW'($past(acc_q[op_acc]) + $past(prod_ext))));

  // R8: preset loads the value one edge later
  p_preset_load_r8: assert property (@(posedge clk) disable iff (rst)
    preset_en |=> (acc_q[$past(preset_idx)] == $past(preset_val)));

  // R6 / R10: untouched accumulators hold
  for (genvar i = 0; i < NACC; i++) begin : g_hold
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (!(op_valid && (op_acc == IDXW'(i))) && !(preset_en && (preset_idx == IDXW'(i))))
      |=> $stable(acc_q[i]));
  end

endmodule

bind mac40_unit mac40_unit_chk #(
  .OPW(OPW), .ACCW(ACCW), .NACC(NACC), .IDXW(IDXW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op_valid   (op_valid),
  .op_sel     (op_sel),
  .op_acc     (op_acc),
  .op_a       (op_a),
  .op_b       (op_b),
  .frac_now   (frac_now),
  .preset_en  (preset_en),
  .preset_idx (preset_idx),
  .preset_val (preset_val),
  .prod_ext   (prod_ext),
  .acc_q      (acc_q)
);

// File: tb/mac40_unit_tb.sv
`timescale 1ns/1ps
module mac40_unit_tb;

  localparam int ACCW = 40;
  localparam logic [15:0] CTL_ON  = 16'h8085;
  localparam logic [15:0] CTL_OFF = 16'h8005;

  logic             clk = 1'b0;
  logic             rst;
  logic             op_valid;
  logic             op_sel;
  logic [0:0]       op_acc;
  logic [15:0]      op_a;
  logic [15:0]      op_b;
  logic [15:0]      ctl_word;
  logic             preset_en;
  logic [0:0]       preset_idx;
  logic [39:0]      preset_val;
  logic [1:0][39:0] acc_q;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int          idx;
    logic [39:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t    sbq[$];
  logic [39:0] model [2];

  always #4 clk = ~clk;

  mac40_unit u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .op_acc(op_acc), .op_a(op_a), .op_b(op_b), .ctl_word(ctl_word),
    .preset_en(preset_en), .preset_idx(preset_idx),
    .preset_val(preset_val), .acc_q(acc_q)
  );

  // Driver: one cycle of stimulus, expected next state pushed for both accs.
  task automatic step(input logic r, input logic v, input logic sel,
                      input int idx, input logic [15:0] a, input logic [15:0] b,
                      input logic [15:0] ctl, input logic pe, input int pidx,
                      input logic [39:0] pv, input string tag);
    longint ma;
    longint p;
    sb_item_t it;
    @(negedge clk);
    rst = r; op_valid = v; op_sel = sel; op_acc = idx[0:0];
    op_a = a; op_b = b; ctl_word = ctl;
    preset_en = pe; preset_idx = pidx[0:0]; preset_val = pv;
    ma = sel ? longint'($signed(a)) : longint'(a);
    p  = ma * longint'(b);
    if (ctl[7]) p = p * 2;
    for (int i = 0; i < 2; i++) begin
      if (r) model[i] = '0;
      else if (pe && pidx == i) model[i] = pv;
      else if (v && idx == i) model[i] = 40'(longint'(model[i]) + p);
      it.idx = i; it.exp = model[i]; it.tag = tag;
      sbq.push_back(it);
    end
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 1'b0, 0, 16'h0, 16'h0, CTL_OFF, 1'b0, 0, 40'h0, tag);
  endtask

  task automatic preset(input int idx, input logic [39:0] val, input string tag);
    step(1'b0, 1'b0, 1'b0, 0, 16'h0, 16'h0, CTL_OFF, 1'b1, idx, val, tag);
  endtask

  task automatic mac(input logic sel, input int idx, input logic [15:0] a,
                     input logic [15:0] b, input logic [15:0] ctl, input string tag);
    step(1'b0, 1'b1, sel, idx, a, b, ctl, 1'b0, 0, 40'h0, tag);
  endtask

  // Monitor: compare queued expectations shortly after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sbq.size() > 0) begin
        sb_item_t it;
        it = sbq.pop_front();
        checks++;
        if (acc_q[it.idx] !== it.exp) begin
          errors++;
          $display("FAIL %s acc%0d actual %h expected %h", it.tag, it.idx,
                   acc_q[it.idx], it.exp);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model[0] = '0; model[1] = '0;
    rst = 1'b1; op_valid = 1'b0; op_sel = 1'b0; op_acc = '0; op_a = '0;
    op_b = '0; ctl_word = CTL_OFF; preset_en = 1'b0; preset_idx = '0;
    preset_val = '0;
    step(1'b1, 1'b0, 1'b0, 0, 16'h0, 16'h0, CTL_OFF, 1'b0, 0, 40'h0, "R9");
    step(1'b1, 1'b0, 1'b0, 0, 16'h0, 16'h0, CTL_OFF, 1'b0, 0, 40'h0, "R9");
    idle("R9");
    @(negedge clk);
    checks++;
    if (acc_q !== '0) begin
      errors++;
      $display("FAIL R9 reset actual %h expected 0", acc_q);
    end

    // R1 unsigned, normal and fractional
    preset(1, 40'h7F_FFFF_FFFF, "R8");
    mac(1'b0, 1, 16'h8001, 16'hFFFF, CTL_OFF, "R1");
    preset(1, 40'h7F_FFFF_FFFF, "R8");
    mac(1'b0, 1, 16'h8001, 16'hFFFF, CTL_ON, "R4");
    // R2 signed-by-unsigned
    preset(1, 40'h7F_FFFF_FFFF, "R8");
    mac(1'b1, 1, 16'h7FFF, 16'hFFFF, CTL_OFF, "R2");
    preset(1, 40'h7F_FFFF_FFFF, "R8");
    mac(1'b1, 1, 16'h7FFF, 16'hFFFF, CTL_ON, "R4");
    preset(1, 40'h7F_FFFF_FFFF, "R8");
    mac(1'b1, 1, 16'h8001, 16'hFFFF, CTL_OFF, "R2");
    preset(1, 40'h7F_FFFF_FFFF, "R8");
    mac(1'b1, 1, 16'h8001, 16'hFFFF, CTL_ON, "R4");
    // R3 wrap
    preset(0, 40'hFF_FFFF_FFFF, "R8");
    mac(1'b0, 0, 16'h0001, 16'h0001, CTL_OFF, "R3");
    mac(1'b1, 0, 16'hFFFF, 16'h0001, CTL_OFF, "R3");
    mac(1'b0, 0, 16'hFFFF, 16'hFFFF, CTL_ON, "R3");
    // R4 only bit 7 matters
    preset(0, 40'h0, "R8");
    mac(1'b0, 0, 16'h0003, 16'h0005, 16'h0080, "R4");
    mac(1'b0, 0, 16'h0003, 16'h0005, 16'hFF7F, "R4");
    // R5 / R7 back to back with toggling mode
    mac(1'b0, 0, 16'h1234, 16'h0100, CTL_ON,  "R5");
    mac(1'b1, 0, 16'hF000, 16'h0010, CTL_OFF, "R5");
    mac(1'b0, 0, 16'hABCD, 16'h0002, CTL_ON,  "R7");
    mac(1'b1, 0, 16'h8000, 16'hFFFF, CTL_ON,  "R7");
    // R6 other accumulator held
    mac(1'b0, 1, 16'h0101, 16'h0202, CTL_OFF, "R6");
    // R10 idle with busy operands
    step(1'b0, 1'b0, 1'b1, 1, 16'hFFFF, 16'hFFFF, CTL_ON, 1'b0, 0, 40'h0, "R10");
    step(1'b0, 1'b0, 1'b0, 0, 16'h5555, 16'hAAAA, CTL_OFF, 1'b0, 1, 40'h12, "R10");
    // R8 preset beats accumulate on same acc; other acc still accumulates
    step(1'b0, 1'b1, 1'b0, 0, 16'h0010, 16'h0010, CTL_OFF, 1'b1, 0, 40'h12_3456_789A, "R8");
    step(1'b0, 1'b1, 1'b0, 1, 16'h0010, 16'h0010, CTL_OFF, 1'b1, 0, 40'h00_0000_0042, "R8");
    // R9 reset beats everything
    step(1'b1, 1'b1, 1'b0, 0, 16'h0010, 16'h0010, CTL_ON, 1'b1, 1, 40'hAB, "R9");
    idle("R9");
    idle("R10");
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule